// File: doc/BRIEF.md
# Speculative Commit Write Buffer

This buffer sits between a fast execution unit and a slower memory write port. The execution side hands over stores before it knows whether the branch they depend on will stand. Each store carries a small branch tag. A store waits in the buffer until a commit pulse names its tag, and only then may it reach memory. A squash pulse for the tag removes it, so memory never has to undo a write.

Stores of a byte, a halfword or a word may sit at any byte offset. They are turned into a word-aligned address, lane-shifted data and per-byte enables. When a new store lands in the same memory word as the youngest buffered store and carries the same tag, the two are folded into one entry, which later becomes one memory write. Committed entries leave strictly oldest-first through a valid/ready port. A load probe compares a load against every pending entry and replies one cycle later. The reply is forwarded bytes, a stall request for partial overlap, or a miss.

Top module: `spec_write_buffer`

## Requirements
- R1: A store stays in the buffer and is not written to memory until a commit pulse (`cm_valid`) names its tag; the commit marks every pending entry of that tag.
- R2: A squash pulse (`sq_valid`) removes every not-yet-committed entry of that tag, and those bytes are never written; entries already committed are not affected by a squash.
- R3: `st_ready` is high unless all DEPTH slots are occupied; a squashed slot stays occupied until it reaches the oldest position, where it is freed at one slot per cycle.
- R4: A store merges into the youngest entry only if that entry is valid, uncommitted, has the same word address and the same tag, and no commit or squash names that tag in the same cycle; merged enables are OR-ed and the new bytes overwrite old ones.
- R5: Size encoding 0 = byte, 1 = halfword, 2 = word; byte enable bit i covers data bits 8i+7..8i, the enables are the size mask shifted left by the address offset (address bits 1..0), and bytes that would pass the end of the word are dropped.
- R6: Only the oldest entry may drain, and only once committed, so memory writes leave in store order; `mem_addr` is the word address with its two low bits zero.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_data` and `mem_be` hold their values.
- R8: One cycle after `ld_valid`, `ld_hit` is high when the youngest pending entry whose word and enables overlap the load covers every requested byte; `ld_data` then holds those bytes right-aligned, with the unrequested upper bytes zero.
- R9: If that youngest overlapping entry covers only some of the requested bytes, `ld_stall` is high, `ld_hit` is low and `ld_data` is zero; hit and stall are never high together.
- R10: A load that overlaps no pending entry gives `ld_hit` and `ld_stall` both low.
- R11: After reset the buffer is empty: `st_ready` high, `mem_valid`, `ld_hit` and `ld_stall` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Buffer can accept a store |
| st_addr | input | AW | Store byte address |
| st_size | input | 2 | Store size (0 byte, 1 half, 2 word) |
| st_data | input | DW | Store data, right-aligned |
| st_tag | input | TAGW | Branch tag of the store |
| cm_valid | input | 1 | Commit pulse |
| cm_tag | input | TAGW | Tag being committed |
| sq_valid | input | 1 | Squash pulse |
| sq_tag | input | TAGW | Tag being squashed |
| ld_valid | input | 1 | Load probe request |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size (0 byte, 1 half, 2 word) |
| ld_hit | output | 1 | Load fully served from the buffer |
| ld_stall | output | 1 | Load partially overlaps a pending store |
| ld_data | output | DW | Forwarded load data, right-aligned |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Word-aligned write address |
| mem_data | output | DW | Write data |
| mem_be | output | DW/8 | Write byte enables |

## Verification
The hardest situation to reach is a committed entry sitting at the head behind back-pressure while a squash for its own tag arrives. A squash is normally issued before a commit, and a committed head normally drains on the next edge. The stimulus holds `mem_ready` low, commits, then squashes the same tag, and checks that the write is still offered unchanged and is delivered once `mem_ready` rises. A second hard case is a squashed hole left in the middle of a full ring. It is reached by filling all slots with one uncommitted tag, squashing it, and watching `st_ready` return only after the holes are popped.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWRD = 2'd3
  } acc_size_e;

  // Byte-lane mask of an access of the given size, shifted to its offset.
  function automatic logic [15:0] lane_mask(input logic [1:0] sz, input logic [3:0] off);
    logic [15:0] base;
    case (acc_size_e'(sz))
      SZ_BYTE: base = 16'h0001;
      SZ_HALF: base = 16'h0003;
      SZ_WORD: base = 16'h000F;
      default: base = 16'h00FF;
    endcase
    return base << off;
  endfunction

endpackage

// File: rtl/swb_store_align.sv
module swb_store_align
  import swb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [$clog2(DW/8)-1:0] off,
  input  logic [1:0]              size,
  input  logic [DW-1:0]           din,
  output logic [DW/8-1:0]         be,
  output logic [DW-1:0]           dout
);
  localparam int BL   = DW / 8;
  localparam int OFFW = $clog2(BL);

  logic [BL-1:0] size_lanes;
  logic [DW-1:0] kept;

  always_comb begin
    size_lanes = BL'(lane_mask(size, 4'd0));
    be         = BL'(lane_mask(size, 4'(off)));
  end

  for (genvar j = 0; j < BL; j++) begin : g_keep
    assign kept[8*j +: 8] = size_lanes[j] ? din[8*j +: 8] : 8'h00;
  end

  assign dout = kept << {off, 3'b000};

endmodule

// File: rtl/swb_load_probe.sv
module swb_load_probe #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int WAW   = 30
) (
  input  logic [DEPTH-1:0]                ent_v,
  input  logic [DEPTH-1:0][WAW-1:0]       ent_wa,
  input  logic [DEPTH-1:0][DW/8-1:0]      ent_be,
  input  logic [DEPTH-1:0][DW-1:0]        ent_d,
  input  logic [$clog2(DEPTH)-1:0]        head,
  input  logic [WAW-1:0]                  q_wa,
  input  logic [DW/8-1:0]                 q_mask,
  input  logic [$clog2(DW/8)-1:0]         q_off,
  output logic                            hit,
  output logic                            partial,
  output logic [DW-1:0]                   fdata
);
  localparam int BL   = DW / 8;
  localparam int PTRW = $clog2(DEPTH);

  logic          found;
  logic [BL-1:0] sel_be;
  logic [DW-1:0] sel_d;
  logic [DW-1:0] shifted;
  logic [BL-1:0] rmask;

  // Walk from oldest to youngest; the last match found is the youngest.
  always_comb begin
    logic [PTRW-1:0] idx;
    found  = 1'b0;
    sel_be = '0;
    sel_d  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTRW'(k);
      if (ent_v[idx] && (ent_wa[idx] == q_wa) && ((ent_be[idx] & q_mask) != '0)) begin
        found  = 1'b1;
        sel_be = ent_be[idx];
        sel_d  = ent_d[idx];
      end
    end
  end

  assign hit     = found && ((sel_be & q_mask) == q_mask);
  assign partial = found && !hit;
  assign shifted = sel_d >> {q_off, 3'b000};
  assign rmask   = q_mask >> q_off;

  for (genvar j = 0; j < BL; j++) begin : g_fwd
    assign fdata[8*j +: 8] = (hit && rmask[j]) ? shifted[8*j +: 8] : 8'h00;
  end

endmodule

// File: rtl/spec_write_buffer.sv
module spec_write_buffer
  import swb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TAGW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [AW-1:0]     st_addr,
  input  logic [1:0]        st_size,
  input  logic [DW-1:0]     st_data,
  input  logic [TAGW-1:0]   st_tag,
  input  logic              cm_valid,
  input  logic [TAGW-1:0]   cm_tag,
  input  logic              sq_valid,
  input  logic [TAGW-1:0]   sq_tag,
  input  logic              ld_valid,
  input  logic [AW-1:0]     ld_addr,
  input  logic [1:0]        ld_size,
  output logic              ld_hit,
  output logic              ld_stall,
  output logic [DW-1:0]     ld_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic [DW/8-1:0]   mem_be
);
  localparam int BL   = DW / 8;
  localparam int OFFW = $clog2(BL);
  localparam int WAW  = AW - OFFW;
  localparam int PTRW = $clog2(DEPTH);
  localparam int CNTW = PTRW + 1;

  // Entry state
  logic [DEPTH-1:0]            ent_v;
  logic [DEPTH-1:0]            ent_c;
  logic [DEPTH-1:0][TAGW-1:0]  ent_tag;
  logic [DEPTH-1:0][WAW-1:0]   ent_wa;
  logic [DEPTH-1:0][BL-1:0]    ent_be;
  logic [DEPTH-1:0][DW-1:0]    ent_d;

  logic [PTRW-1:0] head, tail, youngest;
  logic [CNTW-1:0] count;

  // Store side
  logic [WAW-1:0]  s_wa;
  logic [OFFW-1:0] s_off;
  logic [BL-1:0]   s_be;
  logic [DW-1:0]   s_d;
  logic            accept, do_merge, do_alloc;
  logic            tag_busy;
  logic [PTRW-1:0] wr_idx;

  assign s_wa  = st_addr[AW-1:OFFW];
  assign s_off = st_addr[OFFW-1:0];

  swb_store_align #(.DW(DW)) u_align (
    .off  (s_off),
    .size (st_size),
    .din  (st_data),
    .be   (s_be),
    .dout (s_d)
  );

  assign st_ready = (count != CNTW'(DEPTH));
  assign accept   = st_valid && st_ready;
  assign youngest = tail - PTRW'(1);
  assign tag_busy = (cm_valid && (cm_tag == st_tag)) || (sq_valid && (sq_tag == st_tag));

  assign do_merge = accept && (count != '0) && ent_v[youngest] && !ent_c[youngest]
                    && (ent_wa[youngest] == s_wa) && (ent_tag[youngest] == st_tag)
                    && !tag_busy;
  assign do_alloc = accept && !do_merge;
  assign wr_idx   = do_merge ? youngest : tail;

  // Drain side
  logic head_live, pop;

  assign head_live = (count != '0) && ent_v[head];
  assign mem_valid = head_live && ent_c[head];
  assign mem_addr  = {ent_wa[head], {OFFW{1'b0}}};
  assign mem_data  = ent_d[head];
  assign mem_be    = ent_be[head];
  assign pop       = (count != '0) && (!ent_v[head] || (ent_c[head] && mem_ready));

  // Control state
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      ent_c <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cm_valid && ent_v[i] && (ent_tag[i] == cm_tag))
          ent_c[i] <= 1'b1;
        if (sq_valid && ent_v[i] && !ent_c[i] && (ent_tag[i] == sq_tag))
          ent_v[i] <= 1'b0;
      end
      if (pop) begin
        ent_v[head] <= 1'b0;
        head        <= head + PTRW'(1);
      end
      if (do_merge) begin
        ent_be[youngest] <= ent_be[youngest] | s_be;
      end else if (do_alloc) begin
        ent_v[tail]   <= 1'b1;
        ent_c[tail]   <= 1'b0;
        ent_tag[tail] <= st_tag;
        ent_wa[tail]  <= s_wa;
        ent_be[tail]  <= s_be;
        tail          <= tail + PTRW'(1);
      end
      count <= count + CNTW'(do_alloc) - CNTW'(pop);
    end
  end

  // Data storage with byte write enables, no reset
  always_ff @(posedge clk) begin
    for (int j = 0; j < BL; j++) begin
      if (accept && s_be[j])
        ent_d[wr_idx][8*j +: 8] <= s_d[8*j +: 8];
    end
  end

  // Load probe
  logic [WAW-1:0]  q_wa;
  logic [OFFW-1:0] q_off;
  logic [BL-1:0]   q_mask;
  logic            p_hit, p_partial;
  logic [DW-1:0]   p_data;

  assign q_wa   = ld_addr[AW-1:OFFW];
  assign q_off  = ld_addr[OFFW-1:0];
  assign q_mask = BL'(lane_mask(ld_size, 4'(q_off)));

  swb_load_probe #(.DEPTH(DEPTH), .DW(DW), .WAW(WAW)) u_probe (
    .ent_v   (ent_v),
    .ent_wa  (ent_wa),
    .ent_be  (ent_be),
    .ent_d   (ent_d),
    .head    (head),
    .q_wa    (q_wa),
    .q_mask  (q_mask),
    .q_off   (q_off),
    .hit     (p_hit),
    .partial (p_partial),
    .fdata   (p_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hit   <= 1'b0;
      ld_stall <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_hit   <= ld_valid && p_hit;
      ld_stall <= ld_valid && p_partial;
      ld_data  <= ld_valid ? p_data : '0;
    end
  end

endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            st_ready,
  input logic            ld_valid,
  input logic            ld_hit,
  input logic            ld_stall,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_data,
  input logic [DW/8-1:0] mem_be
);

  p_ready_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> st_ready);

  p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_data) && $stable(mem_be)));

  p_hit_xor_stall_r9: assert property (@(posedge clk) disable iff (rst)
    !(ld_hit && ld_stall));

  p_reply_needs_probe_r8: assert property (@(posedge clk) disable iff (rst)
    (ld_hit || ld_stall) |-> $past(ld_valid));

  p_write_has_bytes_r5: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_be != '0));

endmodule

bind spec_write_buffer swb_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .st_ready  (st_ready),
  .ld_valid  (ld_valid),
  .ld_hit    (ld_hit),
  .ld_stall  (ld_stall),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_be    (mem_be)
);

// File: tb/tb_spec_write_buffer.sv
module tb_spec_write_buffer;
  localparam int AW = 32, DW = 32, TAGW = 3, DEPTH = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic st_valid = 0, st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [1:0] st_size = '0;
  logic [DW-1:0] st_data = '0;
  logic [TAGW-1:0] st_tag = '0, cm_tag = '0, sq_tag = '0;
  logic cm_valid = 0, sq_valid = 0, ld_valid = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [1:0] ld_size = '0;
  logic ld_hit, ld_stall, mem_valid, mem_ready = 1'b1;
  logic [DW-1:0] ld_data, mem_data;
  logic [AW-1:0] mem_addr;
  logic [DW/8-1:0] mem_be;

  spec_write_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, wr_n = 0;
  logic [AW-1:0] wr_a [64];
  logic [DW-1:0] wr_d [64];
  logic [3:0]    wr_b [64];

  always @(posedge clk) begin
    if (!rst && mem_valid && mem_ready && wr_n < 64) begin
      wr_a[wr_n] <= mem_addr;
      wr_d[wr_n] <= mem_data;
      wr_b[wr_n] <= mem_be;
      wr_n <= wr_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d, input logic [2:0] t);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_size = sz; st_data = d; st_tag = t;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic commit(input logic [2:0] t);
    @(negedge clk); cm_valid = 1; cm_tag = t;
    @(negedge clk); cm_valid = 0;
  endtask

  task automatic squash(input logic [2:0] t);
    @(negedge clk); sq_valid = 1; sq_tag = t;
    @(negedge clk); sq_valid = 0;
  endtask

  task automatic load(input logic [31:0] a, input logic [1:0] sz);
    @(negedge clk); ld_valid = 1; ld_addr = a; ld_size = sz;
    @(negedge clk); ld_valid = 0;
  endtask

  task automatic t_reset;
    check("R11 st_ready", 32'(st_ready), 1);
    check("R11 mem_valid", 32'(mem_valid), 0);
    check("R11 ld_hit/stall", {30'd0, ld_hit, ld_stall}, 0);
  endtask

  task automatic t_hold;
    int b = wr_n;
    store(32'h100, 2, 32'h12345678, 1);
    idle(5);
    check("R1 held before commit", wr_n, b);
    load(32'h100, 2);
    check("R8 word hit", 32'(ld_hit), 1);
    check("R8 word data", ld_data, 32'h12345678);
    commit(1);
    idle(3);
    check("R1 written after commit", wr_n, b + 1);
    check("R1 addr", wr_a[b], 32'h100);
    check("R1 be", 32'(wr_b[b]), 32'hF);
    check("R1 data", wr_d[b], 32'h12345678);
  endtask

  task automatic t_squash;
    int b = wr_n;
    store(32'h700, 2, 32'hDEAD0001, 2);
    store(32'h704, 2, 32'hDEAD0002, 3);
    squash(2);
    commit(3);
    commit(2);
    idle(5);
    check("R2 only survivor written", wr_n, b + 1);
    check("R2 survivor addr", wr_a[b], 32'h704);
  endtask

  task automatic t_merge;
    int b = wr_n;
    store(32'h400, 0, 32'h10, 1);
    store(32'h401, 0, 32'h20, 1);
    commit(1);
    idle(4);
    check("R4 merged into one write", wr_n, b + 1);
    check("R4 merged be", 32'(wr_b[b]), 32'h3);
    check("R4 merged data", wr_d[b] & 32'hFFFF, 32'h2010);
    b = wr_n;
    store(32'h400, 0, 32'hAA, 2);
    store(32'h401, 0, 32'hBB, 3);
    commit(2);
    commit(3);
    idle(4);
    check("R4 tags differ -> two writes", wr_n, b + 2);
    check("R4 first be", 32'(wr_b[b]), 32'h1);
    check("R4 second be", 32'(wr_b[b+1]), 32'h2);
  endtask

  task automatic t_align;
    int b = wr_n;
    store(32'h502, 1, 32'hBEEF, 4);
    commit(4);
    idle(4);
    check("R5 half@2 addr", wr_a[b], 32'h500);
    check("R5 half@2 be", 32'(wr_b[b]), 32'hC);
    check("R5 half@2 data", wr_d[b] >> 16, 32'hBEEF);
    store(32'h503, 2, 32'hCAFEF00D, 5);
    commit(5);
    idle(4);
    check("R5 word@3 truncated be", 32'(wr_b[b+1]), 32'h8);
    check("R5 word@3 data", wr_d[b+1] >> 24, 32'h0D);
  endtask

  task automatic t_order;
    int b = wr_n;
    store(32'h600, 2, 32'hA, 3);
    store(32'h604, 2, 32'hB, 4);
    commit(4);
    idle(4);
    check("R6 younger waits for older", wr_n, b);
    commit(3);
    idle(5);
    check("R6 both written", wr_n, b + 2);
    check("R6 first is older", wr_a[b], 32'h600);
    check("R6 second is younger", wr_a[b+1], 32'h604);
  endtask

  task automatic t_backpressure;
    int b = wr_n;
    @(negedge clk); mem_ready = 0;
    store(32'h800, 2, 32'h77, 6);
    commit(6);
    idle(2);
    check("R7 offered", 32'(mem_valid), 1);
    check("R7 addr", mem_addr, 32'h800);
    squash(6);
    idle(3);
    check("R2 committed survives squash", 32'(mem_valid), 1);
    check("R7 addr held", mem_addr, 32'h800);
    @(negedge clk); mem_ready = 1;
    idle(3);
    check("R7 written once ready", wr_n, b + 1);
    check("R7 written addr", wr_a[b], 32'h800);
  endtask

  task automatic t_full;
    int b = wr_n;
    for (int k = 0; k < DEPTH - 1; k++) store(32'h900 + 32'(4*k), 2, 32'(k), 5);
    check("R3 ready below full", 32'(st_ready), 1);
    store(32'h900 + 32'(4*(DEPTH-1)), 2, 32'h99, 5);
    check("R3 not ready when full", 32'(st_ready), 0);
    check("R1 full buffer not drained", wr_n, b);
    squash(5);
    idle(12);
    check("R3 ready after holes freed", 32'(st_ready), 1);
    check("R2 squashed never written", wr_n, b);
  endtask

  task automatic t_load;
    int b = wr_n;
    store(32'h200, 2, 32'hA1B2C3D4, 6);
    load(32'h202, 0);
    check("R8 byte hit", 32'(ld_hit), 1);
    check("R8 byte data", ld_data, 32'hB2);
    load(32'h201, 1);
    check("R8 half data", ld_data, 32'hB2C3);
    store(32'h204, 0, 32'h55, 7);
    load(32'h204, 1);
    check("R9 partial stall", {30'd0, ld_hit, ld_stall}, 32'h1);
    check("R9 partial data zero", ld_data, 0);
    load(32'h300, 2);
    check("R10 miss", {30'd0, ld_hit, ld_stall}, 0);
    store(32'h200, 2, 32'h11223344, 7);
    load(32'h200, 2);
    check("R8 youngest match", ld_data, 32'h11223344);
    squash(6);
    squash(7);
    idle(10);
    check("R2 squashed loads' stores dropped", wr_n, b);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_hold();
    t_squash();
    t_merge();
    t_align();
    t_order();
    t_backpressure();
    t_full();
    t_load();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule